// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces a programmable periodic interrupt for a real-time-clock style peripheral. A slow time base, nominally 32.768 kHz, reaches the block as a one-cycle enable pulse in the system clock domain. Each pulse advances a free-running prescaler count. A rate code and an enable bit, both taken from the control registers, select a power-of-two period. When the enable is set and the code is nonzero, the block fires an event each time the prescaler count crosses a boundary of that period. The boundaries are fixed to the absolute count and do not restart when the setting changes.

Each event sets two sticky status bits, the interrupt-request flag and the periodic flag, and raises the interrupt line. All three stay set until the status-read logic outside the block sends a one-cycle clear pulse. Register decoding and the calendar are handled by the logic around the block. The rate code and enable arrive as plain levels, and the block evaluates them again in every cycle, so a register write takes effect on the next tick.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset the prescaler count is zero, `event_o` is low, `status_o` is 2'b00 and `irq_o` is low.
- R2: The prescaler advances by one on each cycle where `tick_i` is high and wraps modulo 2^16. An event is a pulse on `event_o` in the cycle after the tick whose new count is a multiple of the active period.
- R3: For rate codes 3 to 15 the period is 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R4: Rate codes 1 and 2 act as codes 8 and 9, giving periods of 128 and 256 ticks.
- R5: No event occurs while `pie_en_i` is low or `rate_sel_i` is zero. In that state the status bits and `irq_o` keep their values.
- R6: An event sets both status bits and `irq_o`. Status bit 1 is the interrupt-request flag and bit 0 is the periodic flag. The bits stay set until a clear pulse arrives.
- R7: A high `flag_clr_i` clears both status bits and `irq_o` at the next edge. If an event falls on the same edge, the event wins and the bits stay set.
- R8: A change of rate code or enable takes effect at the next tick without restarting the count. The first event after the change lands on the next absolute boundary of the new period.
- R9: `event_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse of the 32.768 kHz time base |
| rate_sel_i | input | 4 | Rate code, 0 means off |
| pie_en_i | input | 1 | Periodic interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for the status bits from the status-read logic |
| event_o | output | 1 | One-cycle periodic event pulse |
| status_o | output | 2 | Bit 1 interrupt-request flag, bit 0 periodic flag |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with its default parameters: a 16-bit prescaler, a 4-bit rate code, and aliasing of codes 1 and 2 by seven. It delivers a tick every second clock. With that tick spacing, the slowest code's 16384-tick period can be observed twice within the run. The aliased periods and the 4-tick period are measured directly as gaps between events. The bench changes the rate while the count keeps running, which exercises the absolute boundaries. It also holds the clear input high while events fire, so that a clear and an event fall on the same edge.

// File: rtl/prt_pkg.sv
`timescale 1ns/1ps
package prt_pkg;

    // Position of each sticky bit inside the status output
    typedef enum int {
        STAT_PERIODIC = 0,
        STAT_IRQ_REQ  = 1
    } stat_bit_e;

    localparam int STAT_W = 2;

    // Registered state of the top level
    typedef struct packed {
        logic evt;
    } core_state_t;

endpackage

// File: rtl/prt_rate_decode.sv
`timescale 1ns/1ps
module prt_rate_decode #(
    parameter int CNT_W     = 16,
    parameter int RATE_W    = 4,
    parameter int ALIAS_TOP = 2,
    parameter int ALIAS_ADD = 7
) (
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic              enable_i,
    output logic              active_o,
    output logic [CNT_W-1:0]  mask_o
);
    localparam int EFF_W = RATE_W + 1;

    logic [EFF_W-1:0] eff_code;
    logic [EFF_W-1:0] shift;

    always_comb begin
        eff_code = {1'b0, rate_sel_i};
        if (rate_sel_i != '0 && int'(rate_sel_i) <= ALIAS_TOP) begin
            eff_code = eff_code + EFF_W'(ALIAS_ADD);
        end
        shift    = (rate_sel_i == '0) ? '0 : eff_code - 1'b1;
        active_o = enable_i && (rate_sel_i != '0);
        for (int i = 0; i < CNT_W; i++) begin
            mask_o[i] = (i < int'(shift));
        end
    end

endmodule

// File: rtl/prt_prescaler.sv
`timescale 1ns/1ps
module prt_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_next_o = cnt_q + 1'b1;
        cnt_d      = tick_i ? cnt_next_o : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/prt_flag_reg.sv
`timescale 1ns/1ps
module prt_flag_reg #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] flag_d, flag_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            if (set_i)      flag_d[b] = 1'b1;
            else if (clr_i) flag_d[b] = 1'b0;
            else            flag_d[b] = flag_q[b];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[b] <= 1'b0;
            else        flag_q[b] <= flag_d[b];
        end

        assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !flag_q[b]);
        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[b] && !clr_i) |=> flag_q[b]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/periodic_rate_gen.sv
`timescale 1ns/1ps
module periodic_rate_gen #(
    parameter int CNT_W     = 16,
    parameter int RATE_W    = 4,
    parameter int ALIAS_TOP = 2,
    parameter int ALIAS_ADD = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic [RATE_W-1:0]         rate_sel_i,
    input  logic                      pie_en_i,
    input  logic                      flag_clr_i,
    output logic                      event_o,
    output logic [prt_pkg::STAT_W-1:0] status_o,
    output logic                      irq_o
);
    import prt_pkg::*;

    logic             active;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             fire;
    core_state_t      st_d, st_q;

    prt_rate_decode #(
        .CNT_W(CNT_W), .RATE_W(RATE_W),
        .ALIAS_TOP(ALIAS_TOP), .ALIAS_ADD(ALIAS_ADD)
    ) u_decode (
        .rate_sel_i(rate_sel_i),
        .enable_i  (pie_en_i),
        .active_o  (active),
        .mask_o    (mask)
    );

    prt_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .cnt_o     (cnt),
        .cnt_next_o(cnt_next)
    );

    // Boundary of the selected period reached by the incoming tick
    always_comb begin
        fire      = tick_i && active && ((cnt_next & mask) == '0);
        st_d      = st_q;
        st_d.evt  = fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    prt_flag_reg #(.WIDTH(STAT_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fire),
        .clr_i (flag_clr_i),
        .flag_o(status_o)
    );

    assign event_o = st_q.evt;
    assign irq_o   = status_o[STAT_IRQ_REQ];

    assert_evt_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> $past(pie_en_i && rate_sel_i != '0 && tick_i));
    assert_evt_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> ((cnt & $past(mask)) == '0));
    assert_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);
    assert_evt_sets_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> (status_o == 2'b11 && irq_o));

endmodule

// File: tb/tb_periodic_rate_gen.sv
`timescale 1ns/1ps
module tb_periodic_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] rate = 4'd0;
    logic       en = 1'b0;
    logic       clr = 1'b0;
    logic       event_o;
    logic [1:0] status_o;
    logic       irq_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    tick_run = 1'b0;
    int    tick_phase = 0;
    bit    checking = 1'b0;
    string evt_req = "R2";
    string flag_req = "R6";

    // reference model state
    int m_cnt = 0;
    bit m_evt = 1'b0;
    bit m_flag = 1'b0;
    int m_code;
    int m_period;
    bit m_fire;

    // event gap measurement
    longint cyc = 0;
    longint last_evt = -1;
    longint gap = 0;
    int     n_evt = 0;
    bit     prev_evt = 1'b0;

    always #4 clk = ~clk;

    periodic_rate_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .rate_sel_i(rate),
        .pie_en_i  (en),
        .flag_clr_i(clr),
        .event_o   (event_o),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );

    task automatic chk(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural model, written from the requirements
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_evt = 0; m_flag = 0;
        end else begin
            m_code = rate;
            if (m_code == 1 || m_code == 2) m_code = m_code + 7;
            m_period = (m_code == 0) ? 1 : (1 << (m_code - 1));
            m_fire = tick && en && (rate != 0) && (((m_cnt + 1) % m_period) == 0);
            if (tick) m_cnt = (m_cnt + 1) % 65536;
            m_evt = m_fire;
            if (m_fire) m_flag = 1;
            else if (clr) m_flag = 0;
        end
    end

    // tick source: one pulse every second clock while running
    initial begin
        forever begin
            @(negedge clk);
            if (tick_run) begin
                tick_phase = (tick_phase + 1) % 2;
                tick = (tick_phase == 0);
            end else begin
                tick = 1'b0;
            end
        end
    end

    // compare against the model on every clock
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && checking) begin
                chk(evt_req, event_o, m_evt);
                chk(flag_req, {status_o, irq_o}, {m_flag, m_flag, m_flag});
                if (prev_evt && event_o) chk("R9", 1, 0);
                if (event_o) begin
                    if (last_evt >= 0) gap = cyc - last_evt;
                    last_evt = cyc;
                    n_evt++;
                end
                prev_evt = event_o;
            end
        end
    end

    task automatic new_phase(string er, string fr);
        evt_req = er; flag_req = fr;
        last_evt = -1; gap = 0; n_evt = 0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 300000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        run(4);
        // R1: reset state
        chk("R1", event_o, 0);
        chk("R1", status_o, 0);
        chk("R1", irq_o, 0);
        rst_n = 1'b1;
        checking = 1'b1;
        tick_run = 1'b1;
        run(2);
        chk("R1", {status_o, irq_o, event_o}, 0);

        // R5: idle with enable low, then with code zero
        new_phase("R5", "R5");
        rate = 4'd3; en = 1'b0;
        run(200);
        chk("R5", n_evt, 0);
        rate = 4'd0; en = 1'b1;
        run(200);
        chk("R5", n_evt, 0);
        chk("R5", irq_o, 0);

        // R3: code 3 gives 4 ticks, i.e. 8 clocks
        new_phase("R3", "R6");
        rate = 4'd3;
        run(400);
        chk("R3", n_evt > 10, 1);
        chk("R3", gap, 8);
        // R6: flags held with no clear, then R5 idle keeps them
        chk("R6", {status_o, irq_o}, 3'b111);
        new_phase("R5", "R5");
        en = 1'b0;
        run(100);
        chk("R5", {status_o, irq_o}, 3'b111);

        // R7: clear drops flags; clear held while events fire
        new_phase("R2", "R7");
        clr = 1'b1;
        run(2);
        chk("R7", {status_o, irq_o}, 3'b000);
        en = 1'b1; rate = 4'd3;
        run(200);
        clr = 1'b0;
        run(20);
        chk("R7", irq_o, 1);

        // R3: code 6 gives 32 ticks
        new_phase("R3", "R6");
        rate = 4'd6;
        run(400);
        chk("R3", gap, 64);

        // R4: aliased codes
        new_phase("R4", "R6");
        rate = 4'd1;
        run(800);
        chk("R4", gap, 256);
        new_phase("R4", "R6");
        rate = 4'd2;
        run(1600);
        chk("R4", gap, 512);
        new_phase("R4", "R6");
        rate = 4'd8;
        run(800);
        chk("R4", gap, 256);

        // R8: rapid changes mid-period, boundaries stay absolute
        new_phase("R8", "R6");
        for (int i = 0; i < 12; i++) begin
            rate = 4'(3 + (i % 5));
            run(37);
            en = (i % 3 != 0);
        end
        en = 1'b1; rate = 4'd5;
        run(300);
        chk("R8", gap, 32);

        // R3: slowest code, 16384 ticks = 32768 clocks
        new_phase("R3", "R6");
        rate = 4'd15;
        run(70000);
        chk("R3", n_evt >= 2, 1);
        chk("R3", gap, 32768);

        checking = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule